// File: doc/BRIEF.md
# Prefetch Depth Reinforcement Controller

This block sits beside a cache that feeds a pointer-scanning prefetcher. Each cache line carries a small depth tag: the number of speculative links between that line and the last non-speculative request that led to it. A demand request has depth 0, and a prefetch raised by scanning a line of depth d has depth d+1. Once the depth would pass the limit of 3, the prefetch is not issued, so lines already at depth 3 are never scanned.

On a fill, the controller writes the requesting depth into the line's tag. It queues the line for scanning unless the fill came from a page-table walk or the depth is already at the limit. On a hit by a request shallower than the stored tag, the tag is promoted to the request's depth, and the line is queued for rescan at that depth. This restarts a stalled prefetch chain without any history table. A mode input can limit rescans to improvements of at least two levels. Queued scan commands wait in a small FIFO for the line scanner. When the FIFO is full, a new command is discarded, but the tag update still happens.

Top module: `depth_reinforce_ctrl`

## Requirements
- R1: After reset every line tag holds depth 3 (the maximum) and no scan command is offered (`scan_valid` = 0).
- R2: A fill writes the fill's depth into that line's tag in the same cycle, announced on `tag_upd_valid`/`tag_upd_line`/`tag_upd_depth`.
- R3: A fill with `fill_walk` = 0 and depth below 3 queues a scan command carrying the fill's line and depth; a fill at depth 3 queues nothing.
- R4: A fill with `fill_walk` = 1 (page-table walk traffic) never queues a scan command, though its tag is still written.
- R5: A hit whose depth is below the stored tag overwrites the tag with the hit depth; a hit at or above the stored depth changes no tag and queues nothing.
- R6: With `mode_reduced` = 0, every hit that lowers a tag queues a rescan at the hit's depth.
- R7: With `mode_reduced` = 1, a hit queues a rescan only when the stored depth minus the hit depth is at least 2; smaller improvements still update the tag.
- R8: Scan commands leave in the order they were queued; a command arriving while the FIFO holds FIFO_DEPTH entries is discarded, and its tag update still happens.
- R9: When a fill and a hit arrive in the same cycle, the fill is handled and the hit is ignored.
- R10: While `scan_valid` = 1 and `scan_ready` = 0, the offered command stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_reduced | input | 1 | 0: rescan on any depth improvement; 1: only on improvement of 2 or more |
| fill_valid | input | 1 | A line is being filled this cycle |
| fill_line | input | IDXW | Index of the filled line |
| fill_depth | input | 2 | Depth of the request that brought the line in |
| fill_walk | input | 1 | 1 when the fill is page-table walk traffic |
| hit_valid | input | 1 | A request hit a line this cycle |
| hit_line | input | IDXW | Index of the line hit |
| hit_depth | input | 2 | Depth of the hitting request |
| tag_upd_valid | output | 1 | A depth tag is written this cycle |
| tag_upd_line | output | IDXW | Line whose tag is written |
| tag_upd_depth | output | 2 | New tag depth |
| scan_valid | output | 1 | A scan command is offered |
| scan_line | output | IDXW | Line to scan |
| scan_depth | output | 2 | Depth to scan at |
| scan_ready | input | 1 | Scanner accepts the offered command |

## Verification
The assertions assume that the line indices are below NLINES whenever the matching valid is high. They also assume that the scanner may hold `scan_ready` low for any number of cycles. The bench drives only in-range indices. It sweeps every mode, every stored depth and every hit depth, lets the FIFO drain every cycle during the sweep, and then holds `scan_ready` low on purpose to fill the FIFO, overflow it and stall it.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int DW = 2;
  typedef logic [DW-1:0] depth_t;
  localparam depth_t MAX_DEPTH = depth_t'((1 << DW) - 1);

  // a request shallower than the stored tag promotes the line
  function automatic logic promotes(depth_t stored, depth_t req);
    return req < stored;
  endfunction

  // rescan decision: any gain, or a gain of two levels in reduced mode
  function automatic logic wants_rescan(depth_t stored, depth_t req, logic reduced);
    if (req >= stored) return 1'b0;
    if (reduced) return (stored - req) >= depth_t'(2);
    return 1'b1;
  endfunction

  // scanning at the limit would only yield prefetches past the threshold
  function automatic logic may_scan(depth_t d);
    return d != MAX_DEPTH;
  endfunction
endpackage

// File: rtl/depth_tag_store.sv
module depth_tag_store
  import drc_pkg::*;
#(
  parameter int NLINES = 64,
  parameter int IDXW   = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_idx,
  output depth_t          rd_depth,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  depth_t          wr_depth
);
  depth_t tags [NLINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) tags[i] <= MAX_DEPTH;
    end else if (wr_en) begin
      tags[wr_idx] <= wr_depth;
    end
  end

  assign rd_depth = tags[rd_idx];

  AST_TAG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tags[$past(wr_idx)] == $past(wr_depth)); // R2
endmodule

// File: rtl/rescan_fifo.sv
module rescan_fifo
  import drc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDXW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDXW-1:0] push_line,
  input  depth_t          push_depth,
  output logic            full,
  input  logic            pop_ready,
  output logic            out_valid,
  output logic [IDXW-1:0] out_line,
  output depth_t          out_depth
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IDXW-1:0] lines [DEPTH];
  depth_t          deps  [DEPTH];
  logic [PW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]   cnt;
  logic            do_push, do_pop;

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full      = cnt == CW'(DEPTH);
  assign out_valid = cnt != '0;
  assign do_push   = push && !full;
  assign do_pop    = out_valid && pop_ready;
  assign out_line  = lines[rd_ptr];
  assign out_depth = deps[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) begin
      lines[wr_ptr] <= push_line;
      deps[wr_ptr]  <= push_depth;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R8
  AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop_ready |=> full && $stable(wr_ptr)); // R8
  AST_FIFO_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !pop_ready |=> out_valid && $stable(out_line) && $stable(out_depth)); // R10
endmodule

// File: rtl/depth_reinforce_ctrl.sv
module depth_reinforce_ctrl
  import drc_pkg::*;
#(
  parameter int NLINES     = 64,
  parameter int FIFO_DEPTH = 4,
  localparam int IDXW      = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_reduced,
  input  logic            fill_valid,
  input  logic [IDXW-1:0] fill_line,
  input  logic [1:0]      fill_depth,
  input  logic            fill_walk,
  input  logic            hit_valid,
  input  logic [IDXW-1:0] hit_line,
  input  logic [1:0]      hit_depth,
  output logic            tag_upd_valid,
  output logic [IDXW-1:0] tag_upd_line,
  output logic [1:0]      tag_upd_depth,
  output logic            scan_valid,
  output logic [IDXW-1:0] scan_line,
  output logic [1:0]      scan_depth,
  input  logic            scan_ready
);
  // named internal events
  depth_t          stored_depth;
  logic            hit_take, hit_promote, hit_rescan, fill_scan;
  logic            push_req, fifo_full, rescan_dropped;
  logic [IDXW-1:0] push_line;
  depth_t          push_depth;

  assign hit_take    = hit_valid && !fill_valid;
  assign hit_promote = hit_take && promotes(stored_depth, hit_depth);
  assign hit_rescan  = hit_take && wants_rescan(stored_depth, hit_depth, mode_reduced)
                       && may_scan(hit_depth);
  assign fill_scan   = fill_valid && !fill_walk && may_scan(fill_depth);

  assign push_req       = fill_scan || hit_rescan;
  assign push_line      = fill_valid ? fill_line  : hit_line;
  assign push_depth     = fill_valid ? fill_depth : hit_depth;
  assign rescan_dropped = push_req && fifo_full;

  assign tag_upd_valid = fill_valid || hit_promote;
  assign tag_upd_line  = fill_valid ? fill_line  : hit_line;
  assign tag_upd_depth = fill_valid ? fill_depth : hit_depth;

  depth_tag_store #(.NLINES(NLINES), .IDXW(IDXW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (hit_line),
    .rd_depth (stored_depth),
    .wr_en    (tag_upd_valid),
    .wr_idx   (tag_upd_line),
    .wr_depth (tag_upd_depth)
  );

  rescan_fifo #(.DEPTH(FIFO_DEPTH), .IDXW(IDXW)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push_req),
    .push_line  (push_line),
    .push_depth (push_depth),
    .full       (fifo_full),
    .pop_ready  (scan_ready),
    .out_valid  (scan_valid),
    .out_line   (scan_line),
    .out_depth  (scan_depth)
  );

  AST_WALK_NEVER_SCANS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_walk |-> !push_req); // R4
  AST_NO_SCAN_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> push_depth != MAX_DEPTH); // R3
  AST_HIT_NEVER_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && !fill_valid && tag_upd_valid |-> tag_upd_depth < stored_depth); // R5
  AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && hit_valid |-> tag_upd_line == fill_line && tag_upd_depth == fill_depth); // R9
  AST_DROP_KEEPS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_dropped && !fill_valid |-> tag_upd_valid); // R8
  AST_REDUCED_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rescan && mode_reduced |-> tag_upd_valid && (stored_depth - tag_upd_depth) >= depth_t'(2)); // R7
endmodule

// File: tb/depth_reinforce_ctrl_bench.sv
module depth_reinforce_ctrl_bench;
  localparam int NL   = 8;
  localparam int FD   = 4;
  localparam int IW   = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_reduced = 1'b0;
  logic fill_valid = 1'b0, fill_walk = 1'b0, hit_valid = 1'b0, scan_ready = 1'b1;
  logic [IW-1:0] fill_line = '0, hit_line = '0;
  logic [1:0] fill_depth = '0, hit_depth = '0;
  logic tag_upd_valid, scan_valid;
  logic [IW-1:0] tag_upd_line, scan_line;
  logic [1:0] tag_upd_depth, scan_depth;

  int checks = 0;
  int fails  = 0;

  // bench model
  int mtag [NL];
  int ql [FD];
  int qd [FD];
  int qh = 0;
  int qn = 0;

  always #5 clk = ~clk;

  depth_reinforce_ctrl #(.NLINES(NL), .FIFO_DEPTH(FD)) u_depth_reinforce_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_reduced(mode_reduced),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_depth(fill_depth), .fill_walk(fill_walk),
    .hit_valid(hit_valid), .hit_line(hit_line), .hit_depth(hit_depth),
    .tag_upd_valid(tag_upd_valid), .tag_upd_line(tag_upd_line), .tag_upd_depth(tag_upd_depth),
    .scan_valid(scan_valid), .scan_line(scan_line), .scan_depth(scan_depth), .scan_ready(scan_ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic fv, input int fl, input int fd, input logic fw,
                     input logic hv, input int hl, input int hd, input logic md, input logic rdy);
    logic ew, epush;
    int el, ed;
    @(posedge clk);
    #1;
    fill_valid = fv; fill_line = IW'(fl); fill_depth = 2'(fd); fill_walk = fw;
    hit_valid = hv; hit_line = IW'(hl); hit_depth = 2'(hd); mode_reduced = md; scan_ready = rdy;
    @(negedge clk);
    // scan output reflects queue state after the last edge
    chk(req, "scan_valid", int'(scan_valid), int'(qn != 0));
    if (qn != 0 && scan_valid) begin
      chk(req, "scan_line", int'(scan_line), ql[qh]);
      chk(req, "scan_depth", int'(scan_depth), qd[qh]);
    end
    // expected tag update and push for this cycle
    if (fv) begin
      ew = 1'b1; el = fl; ed = fd;
      epush = !fw && fd != 3;
    end else if (hv && hd < mtag[hl]) begin
      ew = 1'b1; el = hl; ed = hd;
      epush = (!md || (mtag[hl] - hd) >= 2) && hd != 3;
    end else begin
      ew = 1'b0; el = 0; ed = 0; epush = 1'b0;
    end
    chk(req, "tag_upd_valid", int'(tag_upd_valid), int'(ew));
    if (ew && tag_upd_valid) begin
      chk(req, "tag_upd_line", int'(tag_upd_line), el);
      chk(req, "tag_upd_depth", int'(tag_upd_depth), ed);
    end
    // advance the model to the next edge
    begin
      logic was_full;
      was_full = (qn == FD);
      if (qn != 0 && rdy) begin qh = (qh + 1) % FD; qn--; end
      if (epush && !was_full) begin
        ql[(qh + qn) % FD] = el; qd[(qh + qn) % FD] = ed; qn++;
      end
      if (ew) mtag[el] = ed;
    end
  endtask

  task automatic idle(input string req, input logic rdy);
    cyc(req, 1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 1'b0, rdy);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) mtag[i] = 3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "scan_valid after reset", int'(scan_valid), 0);

    // R1: every tag starts at 3, so a depth-2 hit promotes each line
    for (int l = 0; l < NL; l++) cyc("R1", 1'b0, 0, 0, 1'b0, 1'b1, l, 2, 1'b0, 1'b1);
    idle("R1", 1'b1);

    // exhaustive sweep: mode x stored depth x hit depth (R2 R3 R5 R6 R7)
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++) begin
          int l;
          l = (m * 16 + s * 4 + d) % NL;
          cyc("R3", 1'b1, l, s, 1'b0, 1'b0, 0, 0, 1'(m), 1'b1);
          cyc((m != 0) ? "R7" : "R6", 1'b0, 0, 0, 1'b0, 1'b1, l, d, 1'(m), 1'b1);
          cyc("R5", 1'b0, 0, 0, 1'b0, 1'b1, l, d, 1'(m), 1'b1);
          idle("R2", 1'b1);
        end

    // R4: page-table walk fill writes the tag but is never scanned
    cyc("R4", 1'b1, 2, 0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b1);
    cyc("R4", 1'b1, 3, 1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b1);
    cyc("R5", 1'b0, 0, 0, 1'b0, 1'b1, 2, 1, 1'b0, 1'b1);
    idle("R4", 1'b1);

    // R9: fill and hit in one cycle; only the fill counts
    cyc("R9", 1'b1, 1, 2, 1'b0, 1'b1, 1, 0, 1'b0, 1'b1);
    cyc("R9", 1'b0, 0, 0, 1'b0, 1'b1, 1, 1, 1'b0, 1'b1);
    idle("R9", 1'b1);
    idle("R9", 1'b1);

    // R8 / R10: stall the scanner, overflow the queue, then drain in order
    for (int l = 0; l < 4; l++) cyc("R8", 1'b1, l, 1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    cyc("R8", 1'b1, 4, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    cyc("R8", 1'b0, 0, 0, 1'b0, 1'b1, 0, 0, 1'b0, 1'b0);
    idle("R10", 1'b0);
    idle("R10", 1'b0);
    for (int k = 0; k < 6; k++) idle("R8", 1'b1);
    // confirm the dropped hit still promoted line 0 to depth 0
    cyc("R8", 1'b0, 0, 0, 1'b0, 1'b1, 0, 0, 1'b0, 1'b1);
    idle("R8", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule